// File: doc/BRIEF.md
# NAND timing parameter converter

This block turns a set of NAND interface timings, given in picoseconds, into the clock-cycle counts that a static-memory NAND bus engine needs. It then packs those counts into two 32-bit words: a control word and a timing word. A configuration sequencer or boot engine sets the timing inputs, the bus clock period in whole nanoseconds and the bus-width flag, and pulses `start`. Some hundreds of cycles later the block raises `done` for one cycle with both words updated. Read-cycle times that are too short for the bus engine are not converted. In that case the block raises `unsupported` instead.

Each field has its own rule. Every timing is first truncated to whole nanoseconds. Some fields then take a ceiling division by the clock period, others take the ceiling and subtract one. Some get a floor of one, and they saturate at different limits. Several fields are built from the maximum, or from the difference, of more than one device timing. A single restoring divider, one quotient bit per clock, performs all twelve divisions in turn. This keeps the block small. Speed does not matter here, because it runs only when the interface mode changes.

Top module: `nand_tim_conv`

## Requirements
- R1: When `start` is accepted with `t_rc_min` below 30000 ps, the next cycle shows `done`=1 and `unsupported`=1, and both words keep their previous values. A `t_rc_min` of exactly 30000 ps is converted normally.
- R2: Each picosecond operand is truncated to whole nanoseconds (integer division by 1000). The cycle count is then c = (ns + period - 1) / period, computed in unsigned 32-bit arithmetic.
- R3: The address-latch count uses c of `t_ar_min`, and the command-latch count uses c of `t_clr_min`. Each field is c-1 in 32 bits, saturated to 15; c=0 wraps and gives 15.
- R4: The hi-Z count is the low 8 bits of c of (`t_cs_min` - `t_wp_min`). The difference is unsigned 32-bit, and no one is subtracted.
- R5: The hold count is c of the largest of `t_dh_min`, `t_ch_min`, `t_clh_min`, `t_wh_min`, `t_alh_min` and `t_reh_min`. A value of 0 becomes 1, and the count saturates at 255.
- R6: The wait count is m = c - 1 (32-bit) of max(`t_rp_min`, `t_wp_min`). m=0 becomes 1, and any m above 255 (including the wrap of c=0) becomes 255.
- R7: The setup count uses the same rule as R6, applied to max(`t_cs_min` - `t_wp_min`, `t_cea_max` - `t_rea_max`), where both differences are unsigned 32-bit.
- R8: The timing word holds setup in bits 7:0, wait in 15:8, hold in 23:16 and hi-Z in 31:24.
- R9: The control word has bits 1, 2 and 3 set to one. Bit 4 equals `bus16`. The command-latch count sits in bits 12:9 and the address-latch count in bits 16:13. All other bits are zero.
- R10: `done` lasts exactly one cycle. On a converted result it comes with `unsupported`=0. Both words change only in a cycle where `done` is high.
- R11: Inputs are sampled in the cycle where `start` is accepted. A `start` received while a conversion is in progress is ignored and gives no extra `done`.
- R12: After reset, both words, `done` and `unsupported` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted when idle) |
| period_ns | input | PW (8) | Bus clock period in whole ns, nonzero |
| bus16 | input | 1 | 16-bit NAND bus |
| t_rc_min | input | 32 | Minimum read-cycle time, ps |
| t_ar_min | input | 32 | Address latch to read enable, ps |
| t_clr_min | input | 32 | Command latch to read enable, ps |
| t_cs_min | input | 32 | Chip-select setup, ps |
| t_wp_min | input | 32 | Write pulse width, ps |
| t_dh_min | input | 32 | Data hold, ps |
| t_ch_min | input | 32 | Chip-select hold, ps |
| t_clh_min | input | 32 | Command latch hold, ps |
| t_wh_min | input | 32 | Write-enable high hold, ps |
| t_alh_min | input | 32 | Address latch hold, ps |
| t_reh_min | input | 32 | Read-enable high hold, ps |
| t_rp_min | input | 32 | Read pulse width, ps |
| t_cea_max | input | 32 | Chip-enable access time, ps |
| t_rea_max | input | 32 | Read-enable access time, ps |
| ctrl_word | output | 32 | Packed control word |
| tim_word | output | 32 | Packed timing word |
| done | output | 1 | One-cycle end-of-conversion pulse |
| unsupported | output | 1 | Last request had a too-short read cycle |

## Verification
The bench starts with a typical asynchronous timing set at two clock periods and both bus widths. These runs separate the field positions and the bus-width bit.

Pairs of values one picosecond apart around a nanosecond boundary show whether truncation to nanoseconds happens before the ceiling. Very large timings at a 1 ns period separate the 15 limit from the 255 limit. Zero and sub-nanosecond timings separate the floor of one from the wrap of a zero ceiling.

A set where the chip-enable minus read-access difference dominates shows which operand the setup maximum picks. Inputs just below and exactly at the read-cycle limit check the unsupported boundary. A second start and new inputs during a conversion show whether sampling really happens only at start.

// File: rtl/nand_tim_pkg.sv
package nand_tim_pkg;
  localparam int unsigned TDW       = 32;
  localparam int unsigned NFIELD    = 6;
  localparam int unsigned PS_PER_NS = 1000;
  localparam int unsigned RC_MIN_PS = 30000;
  localparam int unsigned LATCH_SAT = 15;
  localparam int unsigned BYTE_SAT  = 255;

  typedef enum logic [2:0] {
    F_AR   = 3'd0,
    F_CLR  = 3'd1,
    F_HIZ  = 3'd2,
    F_HOLD = 3'd3,
    F_WAIT = 3'd4,
    F_SET  = 3'd5
  } field_e;

  function automatic logic [TDW-1:0] umax(input logic [TDW-1:0] a, input logic [TDW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // Applies the per-field offset / floor / saturation rule to a ceiling count.
  function automatic logic [7:0] field_rule(input field_e f, input logic [TDW-1:0] c);
    logic [TDW-1:0] m1;
    logic [7:0]     r;
    m1 = c - TDW'(1);
    case (f)
      F_AR, F_CLR: r = (m1 > TDW'(LATCH_SAT)) ? 8'(LATCH_SAT) : m1[7:0];
      F_HIZ:       r = c[7:0];
      F_HOLD:      r = (c == '0) ? 8'd1 : ((c > TDW'(BYTE_SAT)) ? 8'(BYTE_SAT) : c[7:0]);
      default:     r = (m1 == '0) ? 8'd1 : ((m1 > TDW'(BYTE_SAT)) ? 8'(BYTE_SAT) : m1[7:0]);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/nand_tim_div.sv
module nand_tim_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         valid,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          busy;
  logic [W-1:0]  rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  dvs;
  logic [W:0]    trial;
  logic [W:0]    diff;

  always_comb begin
    trial = {rem, quo[W-1]};
    diff  = trial - {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      quo   <= '0;
      dvs   <= '0;
    end else begin
      valid <= 1'b0;
      if (go && !busy) begin
        rem  <= '0;
        quo  <= dividend;
        dvs  <= divisor;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        if (!diff[W]) begin
          rem <= diff[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;
endmodule

// File: rtl/nand_tim_pack.sv
module nand_tim_pack #(
  parameter int DW = 32
) (
  input  logic [7:0]    f_ar,
  input  logic [7:0]    f_clr,
  input  logic [7:0]    f_hiz,
  input  logic [7:0]    f_hold,
  input  logic [7:0]    f_wait,
  input  logic [7:0]    f_set,
  input  logic          bus16,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] tim
);
  localparam int POS_SET  = 0;
  localparam int POS_WAIT = 8;
  localparam int POS_HOLD = 16;
  localparam int POS_HIZ  = 24;
  localparam int POS_W16  = 4;
  localparam int POS_CLR  = 9;
  localparam int POS_AR   = 13;
  localparam logic [DW-1:0] CTRL_FIXED = DW'(32'h0000_000E);

  always_comb begin
    tim  = (DW'(f_set) << POS_SET) | (DW'(f_wait) << POS_WAIT)
         | (DW'(f_hold) << POS_HOLD) | (DW'(f_hiz) << POS_HIZ);
    ctrl = CTRL_FIXED | (DW'(bus16) << POS_W16)
         | (DW'(f_clr) << POS_CLR) | (DW'(f_ar) << POS_AR);
  end
endmodule

// File: rtl/nand_tim_conv.sv
module nand_tim_conv
  import nand_tim_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [PW-1:0]  period_ns,
  input  logic           bus16,
  input  logic [TDW-1:0] t_rc_min,
  input  logic [TDW-1:0] t_ar_min,
  input  logic [TDW-1:0] t_clr_min,
  input  logic [TDW-1:0] t_cs_min,
  input  logic [TDW-1:0] t_wp_min,
  input  logic [TDW-1:0] t_dh_min,
  input  logic [TDW-1:0] t_ch_min,
  input  logic [TDW-1:0] t_clh_min,
  input  logic [TDW-1:0] t_wh_min,
  input  logic [TDW-1:0] t_alh_min,
  input  logic [TDW-1:0] t_reh_min,
  input  logic [TDW-1:0] t_rp_min,
  input  logic [TDW-1:0] t_cea_max,
  input  logic [TDW-1:0] t_rea_max,
  output logic [TDW-1:0] ctrl_word,
  output logic [TDW-1:0] tim_word,
  output logic           done,
  output logic           unsupported
);
  localparam int IW = $clog2(NFIELD);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e         state;
  logic [IW-1:0]  idx;
  logic           ph;
  logic           fin;
  logic [TDW-1:0] ns_q;
  logic [PW-1:0]  per_q;
  logic           w16_q;
  logic [TDW-1:0] src_in [NFIELD];
  logic [TDW-1:0] src_q  [NFIELD];
  logic [7:0]     f_q    [NFIELD];
  logic [TDW-1:0] div_a;
  logic [TDW-1:0] div_b;
  logic           div_valid;
  logic [TDW-1:0] div_q;
  logic [TDW-1:0] ctrl_n;
  logic [TDW-1:0] tim_n;

  // Picosecond operand of each field, formed once at start.
  always_comb begin
    src_in[F_AR]   = t_ar_min;
    src_in[F_CLR]  = t_clr_min;
    src_in[F_HIZ]  = t_cs_min - t_wp_min;
    src_in[F_HOLD] = umax(umax(umax(t_dh_min, t_ch_min), umax(t_clh_min, t_wh_min)),
                          umax(t_alh_min, t_reh_min));
    src_in[F_WAIT] = umax(t_rp_min, t_wp_min);
    src_in[F_SET]  = umax(t_cs_min - t_wp_min, t_cea_max - t_rea_max);
  end

  // Phase 0: ps -> ns; phase 1: ceiling by the clock period.
  always_comb begin
    if (ph) begin
      div_a = ns_q + TDW'(per_q) - TDW'(1);
      div_b = TDW'(per_q);
    end else begin
      div_a = src_q[idx];
      div_b = TDW'(PS_PER_NS);
    end
  end

  nand_tim_div #(.W(TDW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (state == S_ISSUE),
    .dividend (div_a),
    .divisor  (div_b),
    .valid    (div_valid),
    .quotient (div_q)
  );

  nand_tim_pack #(.DW(TDW)) u_pack (
    .f_ar   (f_q[F_AR]),
    .f_clr  (f_q[F_CLR]),
    .f_hiz  (f_q[F_HIZ]),
    .f_hold (f_q[F_HOLD]),
    .f_wait (f_q[F_WAIT]),
    .f_set  (f_q[F_SET]),
    .bus16  (w16_q),
    .ctrl   (ctrl_n),
    .tim    (tim_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      idx         <= '0;
      ph          <= 1'b0;
      fin         <= 1'b0;
      ns_q        <= '0;
      per_q       <= '0;
      w16_q       <= 1'b0;
      done        <= 1'b0;
      unsupported <= 1'b0;
      ctrl_word   <= '0;
      tim_word    <= '0;
    end else begin
      done <= 1'b0;
      fin  <= 1'b0;
      if (fin) begin
        ctrl_word   <= ctrl_n;
        tim_word    <= tim_n;
        done        <= 1'b1;
        unsupported <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (start) begin
            if (t_rc_min < TDW'(RC_MIN_PS)) begin
              done        <= 1'b1;
              unsupported <= 1'b1;
            end else begin
              per_q <= period_ns;
              w16_q <= bus16;
              idx   <= '0;
              ph    <= 1'b0;
              state <= S_ISSUE;
            end
          end
        end
        S_ISSUE: state <= S_WAIT;
        default: begin
          if (div_valid) begin
            if (!ph) begin
              ns_q  <= div_q;
              ph    <= 1'b1;
              state <= S_ISSUE;
            end else if (idx == IW'(NFIELD - 1)) begin
              fin   <= 1'b1;
              state <= S_IDLE;
            end else begin
              idx   <= idx + IW'(1);
              ph    <= 1'b0;
              state <= S_ISSUE;
            end
          end
        end
      endcase
    end
  end

  // Operand and field storage: no reset needed, written before use.
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (state == S_IDLE && start)
        src_q[g] <= src_in[g];
      if (state == S_WAIT && div_valid && ph && idx == IW'(g))
        f_q[g] <= field_rule(field_e'(g), div_q);
    end
  end
endmodule

// File: rtl/nand_tim_conv_chk.sv
module nand_tim_conv_chk (
  input logic        clk,
  input logic        rst,
  input logic        done,
  input logic        unsupported,
  input logic [31:0] ctrl_word,
  input logic [31:0] tim_word
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_words_stable: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(ctrl_word) && $stable(tim_word)));

  a_r1_unsup_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(unsupported) |-> done);

  a_r9_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (done && !unsupported) |-> (ctrl_word[3:1] == 3'b111 && ctrl_word[0] == 1'b0));

  a_r5_hold_floor: assert property (@(posedge clk) disable iff (rst)
    (done && !unsupported) |-> (tim_word[23:16] != 8'd0));

  a_r6_wait_floor: assert property (@(posedge clk) disable iff (rst)
    (done && !unsupported) |-> (tim_word[15:8] != 8'd0));

  a_r7_setup_floor: assert property (@(posedge clk) disable iff (rst)
    (done && !unsupported) |-> (tim_word[7:0] != 8'd0));
endmodule

bind nand_tim_conv nand_tim_conv_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .done        (done),
  .unsupported (unsupported),
  .ctrl_word   (ctrl_word),
  .tim_word    (tim_word)
);

// File: tb/nand_tim_conv_bench.sv
module nand_tim_conv_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  period_ns;
  logic        bus16;
  logic [31:0] t_rc, t_ar, t_clr, t_cs, t_wp, t_dh, t_ch, t_clh;
  logic [31:0] t_wh, t_alh, t_reh, t_rp, t_cea, t_rea;
  logic [31:0] ctrl_word, tim_word;
  logic        done, unsupported;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cycles = 0;

  always #4 clk = ~clk;

  nand_tim_conv u_nand_tim_conv (
    .clk(clk), .rst(rst), .start(start), .period_ns(period_ns), .bus16(bus16),
    .t_rc_min(t_rc), .t_ar_min(t_ar), .t_clr_min(t_clr), .t_cs_min(t_cs),
    .t_wp_min(t_wp), .t_dh_min(t_dh), .t_ch_min(t_ch), .t_clh_min(t_clh),
    .t_wh_min(t_wh), .t_alh_min(t_alh), .t_reh_min(t_reh), .t_rp_min(t_rp),
    .t_cea_max(t_cea), .t_rea_max(t_rea),
    .ctrl_word(ctrl_word), .tim_word(tim_word), .done(done), .unsupported(unsupported)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] cyc(input logic [31:0] ps);
    logic [31:0] ns, p;
    ns = ps / 32'd1000;
    p  = {24'd0, period_ns};
    return (ns + p - 32'd1) / p;
  endfunction

  function automatic logic [31:0] mx(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [7:0] latch_f(input logic [31:0] c);
    logic [31:0] m; m = c - 32'd1;
    return (m > 32'd15) ? 8'd15 : m[7:0];
  endfunction

  function automatic logic [7:0] byte_m1(input logic [31:0] c);
    logic [31:0] m; m = c - 32'd1;
    if (m == 32'd0) return 8'd1;
    if (m > 32'd255) return 8'd255;
    return m[7:0];
  endfunction

  function automatic logic [31:0] exp_tim();
    logic [31:0] h; logic [7:0] hold;
    h = cyc(mx(mx(mx(t_dh, t_ch), mx(t_clh, t_wh)), mx(t_alh, t_reh)));
    hold = (h == 0) ? 8'd1 : ((h > 255) ? 8'd255 : h[7:0]);
    return {cyc(t_cs - t_wp), 24'd0} | {8'd0, hold, 16'd0}
         | {16'd0, byte_m1(cyc(mx(t_rp, t_wp))), 8'd0}
         | {24'd0, byte_m1(cyc(mx(t_cs - t_wp, t_cea - t_rea)))};
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return 32'h0000_000E | ({31'd0, bus16} << 4)
         | ({24'd0, latch_f(cyc(t_clr))} << 9) | ({24'd0, latch_f(cyc(t_ar))} << 13);
  endfunction

  task automatic defaults();
    period_ns = 8'd8; bus16 = 1'b0;
    t_rc = 40000; t_ar = 10000; t_clr = 10000; t_cs = 25000; t_wp = 12000;
    t_dh = 5000; t_ch = 5000; t_clh = 5000; t_wh = 10000; t_alh = 5000;
    t_reh = 10000; t_rp = 12000; t_cea = 25000; t_rea = 20000;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: actual no done expected done", req);
    end
  endtask

  // Full conversion and comparison against the requirement model.
  task automatic convert(input string req);
    logic [31:0] et, ec;
    et = exp_tim(); ec = exp_ctrl();
    pulse_start();
    wait_done(req);
    check({req, " R8 tim_word"}, tim_word, et);
    check({req, " R9 ctrl_word"}, ctrl_word, ec);
    check({req, " R10 unsupported low"}, {31'd0, unsupported}, 32'd0);
    @(negedge clk);
    check({req, " R10 done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    check("R12 ctrl reset", ctrl_word, 32'd0);
    check("R12 tim reset", tim_word, 32'd0);
    check("R12 done reset", {31'd0, done}, 32'd0);
    check("R12 unsup reset", {31'd0, unsupported}, 32'd0);
  endtask

  task automatic t_typical();
    defaults(); convert("R8 typical p8");
    defaults(); period_ns = 8'd20; bus16 = 1'b1; convert("R9 typical p20 w16");
    check("R9 bus16 bit", {31'd0, ctrl_word[4]}, 32'd1);
  endtask

  task automatic t_truncate();
    defaults(); t_cs = t_wp + 32'd16999; convert("R2 below ns edge");
    check("R2 hiz 16999", {24'd0, tim_word[31:24]}, 32'd2);
    defaults(); t_cs = t_wp + 32'd17000; convert("R2 at ns edge");
    check("R4 hiz 17000", {24'd0, tim_word[31:24]}, 32'd3);
  endtask

  task automatic t_saturate();
    defaults(); period_ns = 8'd1; t_ar = 200000; t_wh = 1000000; t_rp = 1000000;
    t_cs = t_wp + 32'd2600000;
    convert("R3 saturate");
    check("R3 ar sat 15", {28'd0, ctrl_word[16:13]}, 32'd15);
    check("R5 hold sat 255", {24'd0, tim_word[23:16]}, 32'd255);
    check("R6 wait sat 255", {24'd0, tim_word[15:8]}, 32'd255);
    check("R4 hiz low byte", {24'd0, tim_word[31:24]}, 32'd40);
  endtask

  task automatic t_floor();
    defaults(); t_ar = 500; t_dh = 0; t_ch = 0; t_clh = 0; t_wh = 0; t_alh = 0; t_reh = 0;
    t_rp = 8000; t_wp = 8000; t_cs = 8000; t_cea = 20000; t_rea = 20000;
    convert("R5 floor");
    check("R3 ar zero ceil wraps", {28'd0, ctrl_word[16:13]}, 32'd15);
    check("R5 hold floor 1", {24'd0, tim_word[23:16]}, 32'd1);
    check("R6 wait floor 1", {24'd0, tim_word[15:8]}, 32'd1);
    check("R7 setup zero ceil wraps", {24'd0, tim_word[7:0]}, 32'd255);
    check("R4 hiz zero", {24'd0, tim_word[31:24]}, 32'd0);
  endtask

  task automatic t_setup_src();
    defaults(); t_cs = t_wp; t_cea = 100000; t_rea = 20000; convert("R7 access diff");
    check("R7 setup from access diff", {24'd0, tim_word[7:0]}, 32'd9);
    defaults(); t_cs = 10000; t_wp = 12000; convert("R4 negative diff wraps");
  endtask

  task automatic t_unsupported();
    logic [31:0] pc, pt;
    pc = ctrl_word; pt = tim_word;
    defaults(); t_rc = 29999;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R1 done on unsupported", {31'd0, done}, 32'd1);
    check("R1 unsupported flag", {31'd0, unsupported}, 32'd1);
    check("R1 ctrl kept", ctrl_word, pc);
    check("R1 tim kept", tim_word, pt);
    defaults(); t_rc = 30000; period_ns = 8'd10; convert("R1 limit 30000 converted");
  endtask

  task automatic t_busy();
    logic [31:0] et, ec;
    int extra = 0;
    defaults(); period_ns = 8'd5;
    et = exp_tim(); ec = exp_ctrl();
    pulse_start();
    repeat (5) @(negedge clk);
    period_ns = 8'd30; t_wh = 90000; t_ar = 60000; bus16 = 1'b1;
    pulse_start();
    wait_done("R11 busy");
    check("R11 tim from first start", tim_word, et);
    check("R11 ctrl from first start", ctrl_word, ec);
    repeat (600) begin @(negedge clk); if (done) extra++; end
    check("R11 no extra done", extra, 32'd0);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_typical();
    t_truncate();
    t_saturate();
    t_floor();
    t_setup_src();
    t_unsupported();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule